// File: doc/BRIEF.md
# Register File and Operate Unit

This block runs the three operate instructions of a 16-bit processor (add, bitwise AND and bitwise complement) against an eight-entry register file of 16-bit words. Each instruction word is decoded, its source registers are read, the second operand is taken from either a register or a sign-extended 5-bit immediate, and the result is written to the destination register at the next rising clock edge.

On the same edge the block raises a one-cycle strobe carrying the written value and destination index, so that the flag logic next to it can update its negative/zero/positive state. An instruction with any other opcode, or a complement whose low six bits are not all ones, changes nothing and raises no strobe. The usual idioms (clearing a register by ANDing it with immediate zero, and negating by complementing then adding one) all go through this path.

Top module: `opu_core`

## Requirements
- R1: While rst_ni is low and after its release, wr_valid_o is 0 and all eight registers hold 0x0000.
- R2: An add (instr_i[15:12] = 4'b0001) with instr_i[5] = 0 writes reg[instr_i[8:6]] + reg[instr_i[2:0]] to reg[instr_i[11:9]].
- R3: With instr_i[5] = 1, the second operand of an add or AND is instr_i[4:0] sign-extended to 16 bits (5'b11111 is -1, 5'b10001 is -15).
- R4: An AND (instr_i[15:12] = 4'b0101) writes the bitwise AND of its two operands; AND with immediate 0 clears the destination.
- R5: A complement (instr_i[15:12] = 4'b1001, instr_i[5:0] = 6'b111111) writes ~reg[instr_i[8:6]] to reg[instr_i[11:9]]; complement then add immediate 1 gives the two's complement negation.
- R6: A complement whose instr_i[5:0] is not 6'b111111 writes no register and raises no strobe.
- R7: An instruction with any opcode other than 0001, 0101 or 1001, or any cycle with instr_valid_i low, writes no register and raises no strobe.
- R8: One clock after an accepted instruction, wr_valid_o is high for one cycle with wr_addr_o = destination and wr_data_o = written value; the following instruction reads the new value.
- R9: When the destination equals a source, the source reads the value held before the edge and the new value is stored at the edge.
- R10: Arithmetic is 16-bit two's complement and wraps silently (0x7FFF + 1 = 0x8000, 0xFFFF + 0xFFFF = 0xFFFE).
- R11: A two-register form reads both of its distinct source registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word is present this cycle |
| instr_i | input | 16 | Instruction word |
| wr_valid_o | output | 1 | Write strobe for the flag logic |
| wr_addr_o | output | 3 | Destination register of the write |
| wr_data_o | output | 16 | Value written |

## Verification
The register contents have no read port, so every value is brought out by issuing an add of a register to itself with immediate zero and watching the strobe. The hardest state to reach is a wrap past the largest positive value, since the immediate only reaches 15: the stimulus loads 1 and doubles it fifteen times through a register added to itself, which also exercises same-register read and write on every step, then complements 0x8000 to get 0x7FFF and adds one. Ignored instructions are followed at once by a read-back of the destination they named, to show it kept its value.

// File: rtl/opu_pkg.sv
package opu_pkg;
  localparam int XLEN     = 16;
  localparam int REG_AW   = 3;
  localparam int NUM_REGS = 1 << REG_AW;
  localparam int IMM_W    = 5;
  localparam int OPC_W    = 4;

  localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_AND = 4'b0101;
  localparam logic [OPC_W-1:0] OPC_NOT = 4'b1001;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_AND = 2'd1,
    FN_NOT = 2'd2
  } alu_fn_e;

  typedef struct packed {
    logic              wen;
    alu_fn_e           fn;
    logic [REG_AW-1:0] dst;
    logic [REG_AW-1:0] sa;
    logic [REG_AW-1:0] sb;
    logic              use_imm;
    logic [XLEN-1:0]   imm;
  } dec_t;
endpackage

// File: rtl/opu_decode.sv
module opu_decode
  import opu_pkg::*;
(
  input  logic            valid_i,
  input  logic [XLEN-1:0] instr_i,
  output dec_t            dec_o
);
  logic [OPC_W-1:0] opc;
  assign opc = instr_i[15:12];

  always_comb begin
    dec_o.dst     = instr_i[11:9];
    dec_o.sa      = instr_i[8:6];
    dec_o.sb      = instr_i[2:0];
    dec_o.use_imm = instr_i[5];
    dec_o.imm     = {{(XLEN-IMM_W){instr_i[IMM_W-1]}}, instr_i[IMM_W-1:0]};
    dec_o.fn      = FN_ADD;
    dec_o.wen     = 1'b0;
    unique case (opc)
      OPC_ADD: begin dec_o.fn = FN_ADD; dec_o.wen = valid_i; end
      OPC_AND: begin dec_o.fn = FN_AND; dec_o.wen = valid_i; end
      OPC_NOT: begin
        dec_o.fn  = FN_NOT;
        // low six bits must be all ones, otherwise no-op
        dec_o.wen = valid_i && (&instr_i[5:0]);
      end
      default: dec_o.wen = 1'b0;
    endcase
  end
endmodule

// File: rtl/opu_alu.sv
module opu_alu
  import opu_pkg::*;
#(
  parameter int DATA_W = XLEN
) (
  input  alu_fn_e           fn_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  always_comb begin
    unique case (fn_i)
      FN_ADD:  y_o = a_i + b_i;  // wraps, no carry out
      FN_AND:  y_o = a_i & b_i;
      FN_NOT:  y_o = ~a_i;
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/opu_regfile.sv
module opu_regfile #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     ra_i,
  input  logic [AW-1:0]     rb_i,
  output logic [DATA_W-1:0] rda_o,
  output logic [DATA_W-1:0] rdb_o,
  input  logic              we_i,
  input  logic [AW-1:0]     wa_i,
  input  logic [DATA_W-1:0] wd_i
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             regs_q[g] <= '0;
      else if (we_i && (wa_i == AW'(g)))       regs_q[g] <= wd_i;
    end
  end

  // two independent read ports, old value on same-cycle write
  assign rda_o = regs_q[ra_i];
  assign rdb_o = regs_q[rb_i];
endmodule

// File: rtl/opu_core.sv
module opu_core
  import opu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_valid_i,
  input  logic [XLEN-1:0]   instr_i,
  output logic              wr_valid_o,
  output logic [REG_AW-1:0] wr_addr_o,
  output logic [XLEN-1:0]   wr_data_o
);
  dec_t            dec;
  logic [XLEN-1:0] src_a, src_b, opnd_b, result;

  opu_decode u_dec (
    .valid_i (instr_valid_i),
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  opu_regfile #(
    .DATA_W   (XLEN),
    .NUM_REGS (NUM_REGS)
  ) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_i   (dec.sa),
    .rb_i   (dec.sb),
    .rda_o  (src_a),
    .rdb_o  (src_b),
    .we_i   (dec.wen),
    .wa_i   (dec.dst),
    .wd_i   (result)
  );

  assign opnd_b = dec.use_imm ? dec.imm : src_b;

  opu_alu #(.DATA_W(XLEN)) u_alu (
    .fn_i (dec.fn),
    .a_i  (src_a),
    .b_i  (opnd_b),
    .y_o  (result)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_valid_o <= dec.wen;
      if (dec.wen) begin
        wr_addr_o <= dec.dst;
        wr_data_o <= result;
      end
    end
  end
endmodule

// File: rtl/opu_checker.sv
module opu_checker
  import opu_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              instr_valid_i,
  input logic [XLEN-1:0]   instr_i,
  input logic              wr_valid_o,
  input logic [REG_AW-1:0] wr_addr_o,
  input logic [XLEN-1:0]   wr_data_o
);
  logic is_legal_op, is_bad_not, is_and_zero;
  assign is_legal_op = (instr_i[15:12] == OPC_ADD) || (instr_i[15:12] == OPC_AND) ||
                       ((instr_i[15:12] == OPC_NOT) && (instr_i[5:0] == 6'h3f));
  assign is_bad_not  = (instr_i[15:12] == OPC_NOT) && (instr_i[5:0] != 6'h3f);
  assign is_and_zero = (instr_i[15:12] == OPC_AND) && instr_i[5] && (instr_i[4:0] == 5'd0);

  a_r1_reset_quiet: assert property (@(posedge clk_i) !rst_ni |-> !wr_valid_o);

  a_r6_bad_not_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && is_bad_not) |=> !wr_valid_o);

  a_r7_no_write_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(instr_valid_i && is_legal_op) |=> !wr_valid_o);

  a_r8_strobe_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && is_legal_op) |=> (wr_valid_o && wr_addr_o == $past(instr_i[11:9])));

  a_r4_and_zero_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && is_and_zero) |=> (wr_data_o == '0));
endmodule

bind opu_core opu_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .instr_valid_i (instr_valid_i),
  .instr_i       (instr_i),
  .wr_valid_o    (wr_valid_o),
  .wr_addr_o     (wr_addr_o),
  .wr_data_o     (wr_data_o)
);

// File: tb/sim_opu_core.sv
module sim_opu_core;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        instr_valid_i;
  logic [15:0] instr_i;
  logic        wr_valid_o;
  logic [2:0]  wr_addr_o;
  logic [15:0] wr_data_o;

  always #10 clk_i = ~clk_i;  // 50 MHz

  opu_core u0 (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .instr_valid_i (instr_valid_i),
    .instr_i       (instr_i),
    .wr_valid_o    (wr_valid_o),
    .wr_addr_o     (wr_addr_o),
    .wr_data_o     (wr_data_o)
  );

  typedef struct {
    logic        wv;
    logic [2:0]  a;
    logic [15:0] d;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [15:0] model [8];
  int          checks = 0;
  int          errors = 0;
  bit          done   = 0;

  function automatic logic [15:0] rr(input logic [3:0] op, input int d, input int s1, input int s2);
    logic [2:0] dd = 3'(d), ss1 = 3'(s1), ss2 = 3'(s2);
    return {op, dd, ss1, 3'b000, ss2};
  endfunction

  function automatic logic [15:0] ri(input logic [3:0] op, input int d, input int s1, input logic [4:0] imm);
    logic [2:0] dd = 3'(d), ss1 = 3'(s1);
    return {op, dd, ss1, 1'b1, imm};
  endfunction

  function automatic logic [15:0] nt(input int d, input int s, input logic [5:0] low);
    logic [2:0] dd = 3'(d), ss = 3'(s);
    return {4'b1001, dd, ss, low};
  endfunction

  // driver: drive at negedge, push expectation from the requirement model
  task automatic issue(input logic v, input logic [15:0] ins, input string tag);
    exp_t e;
    logic [15:0] a, b, y;
    logic ok;
    @(negedge clk_i);
    instr_valid_i = v;
    instr_i       = ins;
    a  = model[ins[8:6]];
    b  = ins[5] ? {{11{ins[4]}}, ins[4:0]} : model[ins[2:0]];
    ok = v;
    case (ins[15:12])
      4'b0001: y = a + b;
      4'b0101: y = a & b;
      4'b1001: begin y = ~a; if (ins[5:0] != 6'h3f) ok = 1'b0; end
      default: begin y = '0; ok = 1'b0; end
    endcase
    e.wv = ok; e.a = ins[11:9]; e.d = y; e.tag = tag;
    sb_q.push_back(e);
    if (ok) model[ins[11:9]] = y;
  endtask

  task automatic readback(input int r, input string tag);
    issue(1'b1, ri(4'b0001, r, r, 5'd0), tag);
  endtask

  // monitor: sample a quarter period after the edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk_i);
      #5;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        checks++;
        if (wr_valid_o !== e.wv || (e.wv && (wr_addr_o !== e.a || wr_data_o !== e.d))) begin
          errors++;
          $display("FAIL %s: got v=%0b a=%0d d=%h, expected v=%0b a=%0d d=%h",
                   e.tag, wr_valid_o, wr_addr_o, wr_data_o, e.wv, e.a, e.d);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got no end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    rst_ni = 1'b0; instr_valid_i = 1'b0; instr_i = '0;
    repeat (2) @(negedge clk_i);
    checks++;
    if (wr_valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: got wr_valid_o=%0b, expected 0", wr_valid_o);
    end
    rst_ni = 1'b1;

    for (int r = 0; r < 8; r++) readback(r, "R1 reset contents");

    issue(1'b1, ri(4'b0101, 0, 0, 5'd0),    "R4 and-zero clear");
    issue(1'b1, ri(4'b0001, 0, 0, 5'b01111), "R3 add +15");
    issue(1'b1, ri(4'b0001, 1, 1, 5'b11111), "R3 add -1");
    issue(1'b1, ri(4'b0001, 2, 0, 5'b10001), "R3 add -15 gives zero");
    issue(1'b1, rr(4'b0001, 3, 0, 1),        "R2 add regs");
    issue(1'b1, rr(4'b0001, 4, 1, 0),        "R11 both sources");
    issue(1'b1, rr(4'b0001, 1, 1, 1),        "R9 R10 dst=src wrap");

    issue(1'b1, ri(4'b0101, 6, 6, 5'd0),     "R4 clear r6");
    issue(1'b1, ri(4'b0001, 6, 6, 5'd1),     "R8 back-to-back");
    for (int k = 0; k < 15; k++) issue(1'b1, rr(4'b0001, 6, 6, 6), "R9 doubling");
    issue(1'b1, nt(7, 6, 6'h3f),             "R5 complement");
    issue(1'b1, ri(4'b0001, 7, 7, 5'd1),     "R10 wrap 0x7fff+1");

    issue(1'b1, rr(4'b0101, 3, 7, 1),        "R4 and regs");
    issue(1'b1, ri(4'b0101, 4, 1, 5'b01010), "R4 and imm");
    issue(1'b1, nt(5, 0, 6'h3f),             "R5 negate step1");
    issue(1'b1, ri(4'b0001, 5, 5, 5'd1),     "R5 negate step2");

    issue(1'b1, nt(0, 1, 6'b111110),         "R6 bad complement");
    readback(0, "R6 r0 unchanged");
    issue(1'b1, ri(4'b0000, 0, 1, 5'd3),     "R7 other opcode");
    issue(1'b1, ri(4'b1100, 2, 1, 5'd3),     "R7 other opcode 1100");
    issue(1'b0, ri(4'b0001, 0, 0, 5'd7),     "R7 valid low");
    readback(0, "R7 r0 unchanged");
    readback(2, "R7 r2 unchanged");

    issue(1'b0, 16'h0000, "R7 idle");
    repeat (3) @(negedge clk_i);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule